// File: doc/BRIEF.md
# Return Address Stack with Fast Register Save

This block keeps the return addresses for subroutine calls and interrupt entries. When the sequencer calls or takes an interrupt, it asserts a push with the 21-bit address to come back to. The block stores that address on top of a last-in, first-out stack of 31 entries. When the sequencer returns, it asserts a pop. The address on top is offered combinationally during that same cycle, and the pointer steps back at the next edge. A 5-bit pointer counts the occupied entries. A value of zero means the stack is empty.

Next to the stack sits a one-deep shadow set for the working register (8 bits), the status flags (5 bits) and the bank select value (4 bits). A push with the fast flag copies the live core values into the shadow set. A pop with the fast flag raises a restore strobe, so the core reloads those three registers from the shadow outputs. A push into a full stack and a pop from an empty stack each raise a sticky error flag. These flags stay set until reset or an explicit clear.

Top module: `ret_addr_stack`

## Requirements
- R1: After synchronous active-high reset, the pointer is 0, both error flags are 0, the top address is 0, all shadow outputs are 0 and the restore strobe is low.
- R2: A push alone with the pointer below 31 raises the pointer by one at the next edge, and from then on the top address equals the pushed address.
- R3: A pop alone with the pointer above 0 presents the most recently pushed, not yet popped address on the top output in the pop cycle itself, and lowers the pointer by one at the next edge (last-in, first-out order).
- R4: A push alone with the pointer at 31 sets the overflow flag and leaves the pointer and every stored entry unchanged.
- R5: While the pointer is 0 the top address reads 0. A pop alone at pointer 0 sets the underflow flag and keeps the pointer at 0.
- R6: Both error flags are sticky: only reset or the clear input lowers them. If an error and a clear arrive in the same cycle, the error wins and the flag ends up set.
- R7: A push with the fast flag copies the live working, status and bank values into the shadow set, visible on the restored outputs after the next edge. This happens even when the push overflows. A push without the fast flag leaves the shadow set unchanged.
- R8: The restore strobe is high exactly in a cycle with pop, fast flag and no push. The restored outputs then carry the shadow set.
- R9: Push and pop asserted together are a no-operation. The pointer, the entries, the flags and the shadow set stay unchanged, and the restore strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Store a return address |
| pop_i | input | 1 | Remove the top return address |
| fast_i | input | 1 | Save (with push) or restore (with pop) the core register shadow |
| flag_clr_i | input | 1 | Clear both sticky error flags |
| push_addr_i | input | 21 | Return address to store |
| live_wreg_i | input | 8 | Current working register value |
| live_status_i | input | 5 | Current status flags |
| live_bank_i | input | 4 | Current bank select value |
| top_addr_o | output | 21 | Address on top of the stack, 0 when empty |
| rest_wreg_o | output | 8 | Shadow working register |
| rest_status_o | output | 5 | Shadow status flags |
| rest_bank_o | output | 4 | Shadow bank select |
| restore_en_o | output | 1 | Core must reload from the shadow outputs this cycle |
| sp_o | output | 5 | Number of occupied entries |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
The stack is filled through every pointer value from 0 to 31 with addresses computed arithmetically, so that each slot holds a distinct pattern. It is then drained completely. This shows that every slot is written and read back in reverse order, and not merely the most recent one. An interleaved push/pop run separates true last-in, first-out order from a plain register of the last address. Pushes beyond full, pops below empty, simultaneous push and pop, and clears that collide with a fresh error tell the error paths apart from the normal stepping. Fast and non-fast pushes with changing live values show that the shadow set is loaded only on request.

// File: rtl/ras_pkg.sv
package ras_pkg;

    localparam int RAS_ADDR_W = 21;
    localparam int RAS_DEPTH  = 31;
    localparam int WREG_W     = 8;
    localparam int STAT_W     = 5;
    localparam int BANK_W     = 4;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PUSH  = 2'd1,
        OP_POP   = 2'd2,
        OP_CLASH = 2'd3
    } stk_op_e;

    typedef struct packed {
        logic [WREG_W-1:0] wreg;
        logic [STAT_W-1:0] status;
        logic [BANK_W-1:0] bank;
    } core_regs_t;

    function automatic stk_op_e decode_op(input logic push, input logic pop);
        case ({push, pop})
            2'b10:   return OP_PUSH;
            2'b01:   return OP_POP;
            2'b11:   return OP_CLASH;
            default: return OP_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH = RAS_DEPTH,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_op_e          op,
    input  logic             flag_clr,
    output logic [PTR_W-1:0] sp,
    output logic             wr_en,
    output logic             ovf,
    output logic             unf
);

    localparam logic [PTR_W-1:0] FULL_VAL = PTR_W'(DEPTH);

    logic is_full;
    logic is_empty;
    logic ovf_evt;
    logic unf_evt;

    always_comb begin
        is_full  = (sp == FULL_VAL);
        is_empty = (sp == '0);
        wr_en    = (op == OP_PUSH) && !is_full;
        ovf_evt  = (op == OP_PUSH) && is_full;
        unf_evt  = (op == OP_POP) && is_empty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
        end else if (wr_en) begin
            sp <= sp + 1'b1;
        end else if ((op == OP_POP) && !is_empty) begin
            sp <= sp - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            if (ovf_evt)       ovf <= 1'b1;
            else if (flag_clr) ovf <= 1'b0;
            if (unf_evt)       unf <= 1'b1;
            else if (flag_clr) unf <= 1'b0;
        end
    end

endmodule

// File: rtl/ras_store.sv
module ras_store
    import ras_pkg::*;
#(
    parameter int DEPTH  = RAS_DEPTH,
    parameter int ADDR_W = RAS_ADDR_W,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  sp,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] top_addr
);

    logic [ADDR_W-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[g] <= '0;
            end else if (wr_en && (sp == PTR_W'(g))) begin
                slot[g] <= wr_addr;
            end
        end
    end

    logic [PTR_W-1:0] rd_idx;

    always_comb begin
        rd_idx   = sp - 1'b1;
        top_addr = '0;
        if (sp != '0) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (rd_idx == PTR_W'(k)) top_addr = slot[k];
            end
        end
    end

endmodule

// File: rtl/ras_shadow.sv
module ras_shadow
    import ras_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  stk_op_e    op,
    input  logic       fast,
    input  core_regs_t live,
    output core_regs_t saved,
    output logic       restore_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            saved <= '0;
        end else if ((op == OP_PUSH) && fast) begin
            saved <= live;
        end
    end

    assign restore_en = (op == OP_POP) && fast;

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
    import ras_pkg::*;
#(
    parameter int DEPTH  = RAS_DEPTH,
    parameter int ADDR_W = RAS_ADDR_W,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              fast_i,
    input  logic              flag_clr_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic [WREG_W-1:0] live_wreg_i,
    input  logic [STAT_W-1:0] live_status_i,
    input  logic [BANK_W-1:0] live_bank_i,
    output logic [ADDR_W-1:0] top_addr_o,
    output logic [WREG_W-1:0] rest_wreg_o,
    output logic [STAT_W-1:0] rest_status_o,
    output logic [BANK_W-1:0] rest_bank_o,
    output logic              restore_en_o,
    output logic [PTR_W-1:0]  sp_o,
    output logic              ovf_o,
    output logic              unf_o
);

    stk_op_e    op;
    logic       wr_en;
    core_regs_t live_regs;
    core_regs_t shadow_regs;

    assign op = decode_op(push_i, pop_i);

    assign live_regs.wreg   = live_wreg_i;
    assign live_regs.status = live_status_i;
    assign live_regs.bank   = live_bank_i;

    ras_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .flag_clr (flag_clr_i),
        .sp       (sp_o),
        .wr_en    (wr_en),
        .ovf      (ovf_o),
        .unf      (unf_o)
    );

    ras_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .sp       (sp_o),
        .wr_addr  (push_addr_i),
        .top_addr (top_addr_o)
    );

    ras_shadow u_shadow (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .fast       (fast_i),
        .live       (live_regs),
        .saved      (shadow_regs),
        .restore_en (restore_en_o)
    );

    assign rest_wreg_o   = shadow_regs.wreg;
    assign rest_status_o = shadow_regs.status;
    assign rest_bank_o   = shadow_regs.bank;

endmodule

// File: rtl/ras_checker.sv
module ras_checker
    import ras_pkg::*;
#(
    parameter int DEPTH  = RAS_DEPTH,
    parameter int ADDR_W = RAS_ADDR_W,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              push_i,
    input logic              pop_i,
    input logic              fast_i,
    input logic              flag_clr_i,
    input logic [ADDR_W-1:0] push_addr_i,
    input logic [WREG_W-1:0] live_wreg_i,
    input logic [ADDR_W-1:0] top_addr_o,
    input logic [WREG_W-1:0] rest_wreg_o,
    input logic              restore_en_o,
    input logic [PTR_W-1:0]  sp_o,
    input logic              ovf_o,
    input logic              unf_o
);

    localparam logic [PTR_W-1:0] FULL_VAL = PTR_W'(DEPTH);

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && sp_o != FULL_VAL) |=> (sp_o == PTR_W'($past(sp_o) + 1'b1))); // R2
    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && sp_o != FULL_VAL) |=> (top_addr_o == $past(push_addr_i))); // R2
    AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && sp_o != '0) |=> (sp_o == PTR_W'($past(sp_o) - 1'b1))); // R3
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && sp_o == FULL_VAL) |=> (ovf_o && sp_o == FULL_VAL && $stable(top_addr_o))); // R4
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && sp_o == '0) |=> (unf_o && sp_o == '0)); // R5
    AST_EMPTY_TOP: assert property (@(posedge clk) disable iff (rst)
        (sp_o == '0) |-> (top_addr_o == '0)); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !flag_clr_i) |=> ovf_o); // R6
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (unf_o && !flag_clr_i) |=> unf_o); // R6
    AST_FAST_SAVE: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && fast_i) |=> (rest_wreg_o == $past(live_wreg_i))); // R7
    AST_RESTORE_STROBE: assert property (@(posedge clk) disable iff (rst)
        restore_en_o |-> (pop_i && fast_i && !push_i)); // R8
    AST_CLASH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i) |=> ($stable(sp_o) && $stable(top_addr_o) && $stable(rest_wreg_o))); // R9

endmodule

bind ret_addr_stack ras_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_ret_addr_stack.sv
module test_ret_addr_stack;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_i = 1'b0, pop_i = 1'b0, fast_i = 1'b0, flag_clr_i = 1'b0;
    logic [20:0] push_addr_i = '0;
    logic [7:0]  live_wreg_i = '0;
    logic [4:0]  live_status_i = '0;
    logic [3:0]  live_bank_i = '0;
    logic [20:0] top_addr_o;
    logic [7:0]  rest_wreg_o;
    logic [4:0]  rest_status_o;
    logic [3:0]  rest_bank_o;
    logic        restore_en_o;
    logic [4:0]  sp_o;
    logic        ovf_o, unf_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ret_addr_stack i_ret_addr_stack (.*);

    function automatic logic [20:0] addr_of(input int i);
        return 21'((i * 32'h0A5A5 + 32'h12345) ^ (i << 14));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic pu, input logic po, input logic fa, input logic cl,
                         input logic [20:0] ad);
        @(negedge clk);
        push_i = pu; pop_i = po; fast_i = fa; flag_clr_i = cl; push_addr_i = ad;
        #1;
    endtask

    task automatic edge_done();
        @(posedge clk);
        #1;
        push_i = 0; pop_i = 0; fast_i = 0; flag_clr_i = 0;
    endtask

    task automatic set_live(input logic [7:0] w, input logic [4:0] s, input logic [3:0] b);
        live_wreg_i = w; live_status_i = s; live_bank_i = b;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        chk("R1 sp", 32'(sp_o), 0);
        chk("R1 ovf", 32'(ovf_o), 0);
        chk("R1 unf", 32'(unf_o), 0);
        chk("R1 top", 32'(top_addr_o), 0);
        chk("R1 shadow", {rest_wreg_o, rest_status_o, rest_bank_o}, 0);
        chk("R1 strobe", 32'(restore_en_o), 0);

        // R2 fill every slot; fast save at depth 5, non-fast at depth 6 (R7)
        for (int i = 1; i <= 31; i++) begin
            if (i == 5) set_live(8'hA7, 5'h15, 4'hC);
            if (i == 6) set_live(8'h3C, 5'h0A, 4'h3);
            drive(1, 0, (i == 5), 0, addr_of(i));
            edge_done();
            chk("R2 sp", 32'(sp_o), 32'(i));
            chk("R2 top", 32'(top_addr_o), 32'(addr_of(i)));
            if (i == 5) chk("R7 fast save", {rest_wreg_o, rest_status_o, rest_bank_o},
                            {8'hA7, 5'h15, 4'hC});
            if (i == 6) chk("R7 no save", {rest_wreg_o, rest_status_o, rest_bank_o},
                            {8'hA7, 5'h15, 4'hC});
        end

        // R4 overflow push, still saves shadow (R7)
        set_live(8'h5E, 5'h1F, 4'h9);
        drive(1, 0, 1, 0, 21'h1FFFFF);
        edge_done();
        chk("R4 ovf", 32'(ovf_o), 1);
        chk("R4 sp", 32'(sp_o), 31);
        chk("R4 top", 32'(top_addr_o), 32'(addr_of(31)));
        chk("R7 save on ovf", {rest_wreg_o, rest_status_o, rest_bank_o}, {8'h5E, 5'h1F, 4'h9});

        // R9 clash when full
        set_live(8'h11, 5'h02, 4'h1);
        drive(1, 1, 1, 0, 21'h0);
        chk("R9 strobe", 32'(restore_en_o), 0);
        edge_done();
        chk("R9 sp", 32'(sp_o), 31);
        chk("R9 top", 32'(top_addr_o), 32'(addr_of(31)));
        chk("R9 shadow", {rest_wreg_o, rest_status_o, rest_bank_o}, {8'h5E, 5'h1F, 4'h9});

        // R3 drain in reverse order; R8 fast restore on first pop
        for (int i = 31; i >= 1; i--) begin
            drive(0, 1, (i == 31), 0, 21'h0);
            chk("R3 top", 32'(top_addr_o), 32'(addr_of(i)));
            chk("R8 strobe", 32'(restore_en_o), 32'(i == 31));
            if (i == 31) chk("R8 restored", {rest_wreg_o, rest_status_o, rest_bank_o},
                             {8'h5E, 5'h1F, 4'h9});
            edge_done();
            chk("R3 sp", 32'(sp_o), 32'(i - 1));
        end
        chk("R6 ovf sticky", 32'(ovf_o), 1);

        // R5 underflow
        drive(0, 1, 0, 0, 21'h0);
        chk("R5 top empty", 32'(top_addr_o), 0);
        edge_done();
        chk("R5 unf", 32'(unf_o), 1);
        chk("R5 sp", 32'(sp_o), 0);

        // R6 clear, then error wins over clear
        drive(0, 0, 0, 1, 21'h0);
        edge_done();
        chk("R6 clr ovf", 32'(ovf_o), 0);
        chk("R6 clr unf", 32'(unf_o), 0);
        drive(0, 1, 0, 1, 21'h0);
        edge_done();
        chk("R6 set wins", 32'(unf_o), 1);
        chk("R6 ovf stays clear", 32'(ovf_o), 0);
        drive(0, 0, 0, 1, 21'h0);
        edge_done();

        // R9 clash when empty
        drive(1, 1, 0, 0, 21'h0ABCD);
        edge_done();
        chk("R9 empty sp", 32'(sp_o), 0);
        chk("R9 empty unf", 32'(unf_o), 0);
        chk("R9 empty ovf", 32'(ovf_o), 0);
        chk("R9 empty top", 32'(top_addr_o), 0);

        // R3 interleaved order
        drive(1, 0, 0, 0, 21'h00111); edge_done();
        drive(1, 0, 0, 0, 21'h00222); edge_done();
        drive(0, 1, 0, 0, 21'h0);
        chk("R3 mix pop1", 32'(top_addr_o), 32'h00222);
        edge_done();
        drive(1, 0, 0, 0, 21'h00333); edge_done();
        drive(0, 1, 0, 0, 21'h0);
        chk("R3 mix pop2", 32'(top_addr_o), 32'h00333);
        edge_done();
        drive(0, 1, 0, 0, 21'h0);
        chk("R3 mix pop3", 32'(top_addr_o), 32'h00111);
        edge_done();
        chk("R3 mix sp", 32'(sp_o), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule